// File: doc/BRIEF.md
# Multi-Rule Floating-Point Minimum/Maximum Unit

This block takes two single-precision floating-point operands and a 4-bit operation code, and returns either the smaller or the larger operand. It can apply any one of sixteen comparison rules. Four rule families are supported:

- the 2008 "number-preferring" rule;
- the 2019 NaN-propagating rule;
- the 2019 number-preferring rule;
- a plain C conditional-expression rule.

Each family has a min form and a max form. Each of those eight also has a magnitude form. The magnitude form compares absolute values first and falls back to its base rule when the magnitudes tie or a NaN is present.

Operands arrive with `in_valid`. The result and an invalid-operation flag appear on the registered outputs one cycle later. A new operation can be issued every cycle. NaN results are always quiet. Any signalling NaN operand raises the invalid flag. The ordered comparison works directly on sign-magnitude bit patterns. It therefore places -0.0 below +0.0, and it orders subnormals and infinities by their encodings without any arithmetic.

Top module: `fp_minmax_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it is released with no input, `out_valid` and `out_invalid` are 0.
- R2: `in_op` is decoded as follows. Bit 0 selects max (1) or min (0). Bits 2:1 select the family: 00 = 2008 number rule, 01 = 2019 NaN-propagating rule, 10 = 2019 number rule, 11 = C conditional rule. Bit 3 selects the magnitude form. Every result is operand A, operand B, a quieted copy of one of them, or the canonical quiet NaN 0x7FC00000.
- R3: 2008 number rule (family 00).
  - If either operand is a signalling NaN, or both are NaN, the result is 0x7FC00000.
  - If exactly one operand is a quiet NaN, the result is the other operand.
  - Otherwise values are ordered with -0.0 strictly below +0.0. Min of the two zeros is 0x80000000 and max is 0x00000000.
- R4: 2019 NaN-propagating rule (family 01). If either operand is any NaN, the result is 0x7FC00000. Otherwise it follows the same ordering as R3, with -0.0 below +0.0.
- R5: 2019 number rule (family 10). If exactly one operand is a NaN, quiet or signalling, the result is the other operand. If both are NaN, the result is 0x7FC00000. Otherwise it follows the ordering of R3.
- R6: C conditional rule (family 11).
  - Min returns A when A < B and B otherwise.
  - Max returns A when A > B and B otherwise.
  - The comparison treats ±0 as equal, and any comparison involving a NaN is false.
- R7: Magnitude forms (bit 3 = 1). When neither operand is NaN and the absolute values differ, min returns the operand with the smaller absolute value and max returns the one with the larger. When the absolute values are equal, or either operand is NaN, the base rule of R3–R6 is applied to the original operands.
- R8: `out_invalid` is 1 exactly when at least one operand of the accepted operation is a signalling NaN. A NaN has exponent all ones and a nonzero fraction; it is signalling when fraction bit 22 is 0.
- R9: A NaN result always has fraction bit 22 set to 1, i.e. it is quiet.
- R10: `out_valid` equals `in_valid` delayed by one clock, and a new operation is accepted on every cycle with no stall.
- R11: The ordering is correct for subnormals, ±infinity and values of opposite sign. +inf is above every finite value and -inf is below every finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 4 | Operation code (see R2) |
| in_a | input | 32 | Operand A, single-precision bit pattern |
| in_b | input | 32 | Operand B, single-precision bit pattern |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Selected operand or canonical quiet NaN |
| out_invalid | output | 1 | A signalling NaN was present in the operation |

## Verification
A fault in the operand classification or in the ordering logic shows up on `out_result` in the very next cycle. Typical symptoms are a zero of the wrong sign, a NaN passed through where the other operand was due, or the smaller-magnitude operand returned by a max form. A stuck or wrong flag path shows on `out_invalid` in the same cycle as the result. Because the unit holds no state beyond its single output register, no error can stay hidden for more than one operation. The bench therefore compares every accepted operation against a bit-pattern reference in the following cycle. It sweeps all sixteen codes over zeros, NaNs of both kinds, infinities, subnormals and equal-magnitude pairs, and then continues with mixed random operands.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int MAG_W  = WORD_W - 1;
    localparam int OP_W   = 4;
    localparam int N_OPND = 2;

    typedef logic [WORD_W-1:0] fp_word_t;

    typedef enum logic [1:0] {
        FAM_NUM08  = 2'b00,
        FAM_IEEE19 = 2'b01,
        FAM_NUM19  = 2'b10,
        FAM_CTERN  = 2'b11
    } family_e;

    // Packed so that bit 3 = magnitude, bits 2:1 = family, bit 0 = max
    typedef struct packed {
        logic    use_mag;
        family_e fam;
        logic    want_max;
    } op_t;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
    } fp_class_t;

    typedef struct packed {
        logic a_lt_b;    // total order, -0 below +0
        logic b_lt_a;
        logic a_lt_b_c;  // relational order, zeros equal, NaN unordered
        logic b_lt_a_c;
        logic mag_lt;    // |a| < |b|
        logic mag_gt;    // |a| > |b|
    } order_t;

    localparam fp_word_t CANON_QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    function automatic fp_word_t quieten(input fp_word_t w);
        fp_word_t r;
        r = w;
        if ((&w[WORD_W-2 -: EXP_W]) && (|w[MAN_W-1:0]))
            r[MAN_W-1] = 1'b1;
        return r;
    endfunction

    // Sign-magnitude ordering of two non-NaN values, -0 strictly below +0
    function automatic logic total_less(input fp_class_t x, input fp_class_t y);
        logic r;
        if (x.sign != y.sign)
            r = x.sign;
        else if (!x.sign)
            r = (x.mag < y.mag);
        else
            r = (x.mag > y.mag);
        return r;
    endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
(
    input  fp_word_t  word,
    output fp_class_t cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             man_nz;

    assign exp_f    = word[WORD_W-2 -: EXP_W];
    assign man_f    = word[MAN_W-1:0];
    assign exp_ones = &exp_f;
    assign man_nz   = |man_f;

    always_comb begin
        cls.sign    = word[WORD_W-1];
        cls.mag     = word[MAG_W-1:0];
        cls.is_nan  = exp_ones & man_nz;
        cls.is_snan = exp_ones & man_nz & ~man_f[MAN_W-1];
        cls.is_zero = ~|word[MAG_W-1:0];
    end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
    import fpmm_pkg::*;
(
    input  fp_class_t ca,
    input  fp_class_t cb,
    output order_t    ord
);
    logic any_nan;
    logic both_zero;
    logic tot_ab;
    logic tot_ba;

    assign any_nan   = ca.is_nan | cb.is_nan;
    assign both_zero = ca.is_zero & cb.is_zero;
    assign tot_ab    = total_less(ca, cb);
    assign tot_ba    = total_less(cb, ca);

    always_comb begin
        ord.a_lt_b   = tot_ab;
        ord.b_lt_a   = tot_ba;
        ord.a_lt_b_c = tot_ab & ~both_zero & ~any_nan;
        ord.b_lt_a_c = tot_ba & ~both_zero & ~any_nan;
        ord.mag_lt   = (ca.mag < cb.mag);
        ord.mag_gt   = (ca.mag > cb.mag);
    end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
    import fpmm_pkg::*;
(
    input  op_t       op,
    input  fp_word_t  a,
    input  fp_word_t  b,
    input  fp_class_t ca,
    input  fp_class_t cb,
    input  order_t    ord,
    output fp_word_t  result,
    output logic      invalid
);
    logic     any_nan;
    logic     both_nan;
    logic     any_snan;
    fp_word_t ordered_pick;
    fp_word_t base_pick;
    fp_word_t final_pick;

    assign any_nan  = ca.is_nan | cb.is_nan;
    assign both_nan = ca.is_nan & cb.is_nan;
    assign any_snan = ca.is_snan | cb.is_snan;

    always_comb begin
        if (op.want_max)
            ordered_pick = ord.a_lt_b ? b : a;
        else
            ordered_pick = ord.a_lt_b ? a : b;
    end

    always_comb begin
        base_pick = ordered_pick;
        unique case (op.fam)
            FAM_NUM08: begin
                if (any_snan || both_nan) base_pick = CANON_QNAN;
                else if (ca.is_nan)       base_pick = b;
                else if (cb.is_nan)       base_pick = a;
            end
            FAM_IEEE19: begin
                if (any_nan) base_pick = CANON_QNAN;
            end
            FAM_NUM19: begin
                if (both_nan)        base_pick = CANON_QNAN;
                else if (ca.is_nan)  base_pick = b;
                else if (cb.is_nan)  base_pick = a;
            end
            FAM_CTERN: begin
                if (op.want_max) base_pick = ord.b_lt_a_c ? a : b;
                else             base_pick = ord.a_lt_b_c ? a : b;
            end
            default: base_pick = ordered_pick;
        endcase
    end

    always_comb begin
        final_pick = base_pick;
        if (op.use_mag && !any_nan && (ord.mag_lt || ord.mag_gt)) begin
            if (op.want_max) final_pick = ord.mag_gt ? a : b;
            else             final_pick = ord.mag_lt ? a : b;
        end
    end

    assign result  = quieten(final_pick);
    assign invalid = any_snan;
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fpmm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     in_op,
    input  logic [WORD_W-1:0]   in_a,
    input  logic [WORD_W-1:0]   in_b,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_result,
    output logic                out_invalid
);
    fp_word_t  opnd [N_OPND];
    fp_class_t cls  [N_OPND];
    order_t    ord;
    op_t       op_dec;
    fp_word_t  sel_result;
    logic      sel_invalid;

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;
    assign op_dec  = op_t'(in_op);

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_class
        fpmm_classify u_class (
            .word (opnd[gi]),
            .cls  (cls[gi])
        );
    end

    fpmm_order u_order (
        .ca  (cls[0]),
        .cb  (cls[1]),
        .ord (ord)
    );

    fpmm_select u_select (
        .op      (op_dec),
        .a       (opnd[0]),
        .b       (opnd[1]),
        .ca      (cls[0]),
        .cb      (cls[1]),
        .ord     (ord),
        .result  (sel_result),
        .invalid (sel_invalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= sel_result;
                out_invalid <= sel_invalid;
            end
        end
    end
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker
    import fpmm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_invalid
);
    logic a_nan, b_nan, a_sig, b_sig, res_nan;

    assign a_nan   = (in_a[30:23] == 8'hFF) && (in_a[22:0] != 0);
    assign b_nan   = (in_b[30:23] == 8'hFF) && (in_b[22:0] != 0);
    assign a_sig   = a_nan && !in_a[22];
    assign b_sig   = b_nan && !in_b[22];
    assign res_nan = (out_result[30:23] == 8'hFF) && (out_result[22:0] != 0);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_nan) |-> out_result[22]);

    assert_snan_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_sig || b_sig)) |=> out_invalid);

    assert_no_spurious_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !a_sig && !b_sig) |=> !out_invalid);

    assert_nan_propagates_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op[2:0] == 3'b010 || in_op[2:0] == 3'b011) && (a_nan || b_nan))
        |=> (out_result == 32'h7FC0_0000));

    // R2: every result is drawn from the operands or is the canonical NaN
    assert_result_source_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_result == $past(in_a) || out_result == $past(in_b) ||
                      out_result == ($past(in_a) | 32'h0040_0000) ||
                      out_result == ($past(in_b) | 32'h0040_0000) ||
                      out_result == 32'h7FC0_0000));
endmodule

bind fp_minmax_unit fpmm_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/fp_minmax_unit_tb.sv
module fp_minmax_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string phase = "";

    typedef struct {
        bit          v;
        logic [31:0] r;
        bit          inv;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        string       ph;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    fp_minmax_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    // ---------------- reference model ----------------
    function automatic bit isn(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit iss(input logic [31:0] x);
        return isn(x) && !x[22];
    endfunction
    // monotone unsigned key: -0 sorts just below +0
    function automatic logic [31:0] key(input logic [31:0] x);
        return x[31] ? ~x : (x ^ 32'h8000_0000);
    endfunction
    function automatic bit tlt(input logic [31:0] x, input logic [31:0] y);
        return key(x) < key(y);
    endfunction
    function automatic bit clt(input logic [31:0] x, input logic [31:0] y);
        if (isn(x) || isn(y)) return 0;
        if ((x[30:0] == 0) && (y[30:0] == 0)) return 0;
        return tlt(x, y);
    endfunction

    function automatic void ref_model(input logic [3:0] op, input logic [31:0] a,
                                      input logic [31:0] b, output logic [31:0] r,
                                      output bit inv);
        logic [31:0] cq = 32'h7FC0_0000;
        logic [31:0] ord;
        bit mx = op[0];
        ord = mx ? (tlt(a, b) ? b : a) : (tlt(a, b) ? a : b);
        case (op[2:1])
            2'd0: r = (iss(a) || iss(b) || (isn(a) && isn(b))) ? cq :
                      isn(a) ? b : isn(b) ? a : ord;
            2'd1: r = (isn(a) || isn(b)) ? cq : ord;
            2'd2: r = (isn(a) && isn(b)) ? cq : isn(a) ? b : isn(b) ? a : ord;
            default: r = mx ? (clt(b, a) ? a : b) : (clt(a, b) ? a : b);
        endcase
        if (op[3] && !isn(a) && !isn(b) && (a[30:0] != b[30:0])) begin
            if (mx) r = (a[30:0] > b[30:0]) ? a : b;
            else    r = (a[30:0] < b[30:0]) ? a : b;
        end
        if (isn(r)) r[22] = 1'b1;
        inv = iss(a) || iss(b);
    endfunction

    function automatic string rtag(input logic [3:0] op);
        if (op[3]) return "R7";
        case (op[2:1])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_out(input exp_t e);
        checks++;
        if (out_valid !== e.v) begin
            errors++;
            $display("FAIL R10 out_valid got %0b exp %0b", out_valid, e.v);
        end
        if (e.v) begin
            checks++;
            if (out_result !== e.r) begin
                errors++;
                $display("FAIL %s [%s] op=%h a=%h b=%h got %h exp %h",
                         rtag(e.op), e.ph, e.op, e.a, e.b, out_result, e.r);
            end
            checks++;
            if (out_invalid !== e.inv) begin
                errors++;
                $display("FAIL R8 op=%h a=%h b=%h got %0b exp %0b",
                         e.op, e.a, e.b, out_invalid, e.inv);
            end
            if (isn(e.r)) begin
                checks++;
                if (out_result[22] !== 1'b1) begin
                    errors++;
                    $display("FAIL R9 quiet bit got %0b exp 1", out_result[22]);
                end
            end
        end
    endtask

    task automatic step(input bit v, input logic [3:0] op,
                        input logic [31:0] a, input logic [31:0] b);
        exp_t e, n;
        @(negedge clk);
        e = q.pop_front();
        check_out(e);
        in_valid = v; in_op = op; in_a = a; in_b = b;
        n.v = v; n.op = op; n.a = a; n.b = b; n.ph = phase;
        n.r = '0; n.inv = 0;
        if (v) ref_model(op, a, b, n.r, n.inv);
        q.push_back(n);
    endtask

    function automatic logic [31:0] rand_val(input logic [31:0] other);
        logic [31:0] x = $urandom;
        case ($urandom_range(0, 7))
            0: x = {x[31], 31'd0};
            1: x = {x[31], 8'hFF, 23'd0};
            2: x = {x[31], 8'hFF, 1'b1, x[21:0]};
            3: x = {x[31], 8'hFF, 1'b0, x[21:1], 1'b1};
            4: x = {x[31], 8'h00, x[22:0]};
            5: x = {~other[31], other[30:0]};
            6: x = other;
            default: ;
        endcase
        return x;
    endfunction

    localparam int NP = 14;
    logic [31:0] pa [NP] = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'h7FC0_0001,
                             32'h7F80_0001, 32'h4000_0000, 32'h7FC0_0000, 32'h7F80_0000,
                             32'h0000_0001, 32'hBF80_0000, 32'h3FC0_0000, 32'hC040_0000,
                             32'h40A0_0000, 32'hFF80_0003};
    logic [31:0] pb [NP] = '{32'h8000_0000, 32'h0000_0000, 32'h7FC0_0001, 32'h3F80_0000,
                             32'h4000_0000, 32'h7F80_0001, 32'hFFC1_0000, 32'hFF80_0000,
                             32'h0000_0100, 32'h3F80_0000, 32'hBFC0_0000, 32'h4000_0000,
                             32'h40A0_0000, 32'h7FC0_0000};

    initial begin
        exp_t z;
        z.v = 0; z.r = '0; z.inv = 0; z.op = '0; z.a = '0; z.b = '0; z.ph = "R1";
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_invalid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset got v=%0b inv=%0b exp 0 0", out_valid, out_invalid);
        end
        rst = 1'b0;
        q.push_back(z);
        step(0, 4'h0, 32'h0, 32'h0);   // first post-reset cycle idle (R1)

        phase = "R2/R11 sweep";
        for (int op = 0; op < 16; op++)
            for (int p = 0; p < NP; p++)
                step(1, 4'(op), pa[p], pb[p]);

        phase = "R10 gaps";
        for (int i = 0; i < 200; i++)
            step(i % 3 != 0, 4'($urandom), rand_val(32'h3F80_0000), rand_val(32'hC000_0000));

        phase = "random";
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            a = rand_val($urandom);
            step(1, 4'($urandom), a, rand_val(a));
        end
        step(0, 4'h0, 32'h0, 32'h0);
        step(0, 4'h0, 32'h0, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule